// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small microcoded processor. It steps a microprogram counter through an internal read-only control store and latches each fetched microinstruction into a control word register. The fields of that register drive the datapath. A few bits leave the block directly as control lines. A 3-bit encoded field is decoded into one-hot register-load strobes, and a 4-bit encoded field is decoded into one-hot output-enable strobes. In both encoded fields code 0 means no strobe.

The next control-store address comes from the current microinstruction's sequencing field. The counter can step by one, jump to the word's branch field, or jump to the branch field only when a selected condition flag is set. It can also jump to the start address of the routine for the opcode held in the instruction register.

The control word register and the microprogram counter are updated on alternate edges of one clock. This models two separate clocks as two clock enables. Each microinstruction therefore occupies two cycles. The `adv_o` output marks the second cycle. The edge that closes that cycle advances the counter, and the datapath captures its register-load strobes on that edge.

The control store is a fixed 32-word table. Word 0 is the fetch routine. It loads the instruction register and then dispatches on the opcode.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low, and for the first two rising edges after it goes high, `upc_o` is 0, `adv_o` is 0, and `ctl_o`, `ld_stb_o` and `oe_stb_o` are all zero. The assertion of reset is asynchronous.
- R2: After reset, `adv_o` alternates 0,1,0,1 from cycle to cycle. The control word outputs change only on the edge that ends an `adv_o`=0 cycle. `upc_o` changes only on the edge that ends an `adv_o`=1 cycle.
- R3: Sequencing code 00 (increment) sets the counter to its present value plus one.
- R4: Sequencing code 01 (jump) loads the 5-bit branch field of the control word.
- R5: Sequencing code 10 loads the branch field if a flag is set, and otherwise increments. The flag is chosen by the 2-bit condition field: 0 = `flags_i[0]` zero, 1 = `flags_i[1]` carry, 2 = `flags_i[2]` sign, 3 = `flags_i[3]` overflow.
- R6: Sequencing code 11 loads the routine start address for `opcode_i`:
  - opcodes 0 to 7 map to 2, 3, 5, 8, 11, 14, 17, 21;
  - opcodes 8 to 15 map to 2.
- R7: `ld_stb_o` has bit k set, and only that bit, when the 3-bit load field holds k, for k from 1 to 7. Load code 0 drives all bits low, and bit 0 is never set.
- R8: `oe_stb_o` has bit k set, and only that bit, when the 4-bit output-enable field holds k, for k from 1 to 15. Code 0 drives all bits low, and bit 0 is never set.
- R9: `ctl_o` equals the 4-bit horizontal field of the control word, unencoded.
- R10: Incrementing from address 31 wraps the counter to 0.
- R11: `opcode_i` and `flags_i` affect the counter only through codes 11 and 10 respectively, and only at the advancing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opcode_i | input | 4 | Opcode from the instruction register |
| flags_i | input | 4 | Condition flags: zero, carry, sign, overflow (bits 0..3) |
| upc_o | output | 5 | Microprogram counter |
| adv_o | output | 1 | High in the cycle whose closing edge advances the counter |
| ctl_o | output | 4 | Direct (horizontal) control lines |
| ld_stb_o | output | 8 | One-hot register-load strobes (bit 0 unused) |
| oe_stb_o | output | 16 | One-hot register output-enable strobes (bit 0 unused) |

## Verification
The hardest situation to reach is a conditional branch in which the selected flag differs from the other flags at the moment of the advancing edge. A second hard case is the wrap from address 31, which only one opcode's routine reaches.

The stimulus drives fresh random flags and opcodes every cycle, so each conditional word sees both outcomes many times while the unselected flags vary. Before that phase, two directed stretches hold all flags set and then all flags clear, forcing every branch taken and then every branch not taken. A reset pulse in the middle of the run repeats the reset checks from a non-zero state.

// File: rtl/useq_pkg.sv
package useq_pkg;
  parameter int ADDR_W  = 5;
  parameter int OPC_W   = 4;
  parameter int NFLAG   = 4;
  parameter int CTL_W   = 4;
  parameter int LD_W    = 3;
  parameter int OE_W    = 4;
  localparam int CND_W  = $clog2(NFLAG);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NLD    = 1 << LD_W;
  localparam int NOE    = 1 << OE_W;

  typedef enum logic [1:0] {
    SEQ_INC = 2'b00,
    SEQ_JMP = 2'b01,
    SEQ_CND = 2'b10,
    SEQ_MAP = 2'b11
  } seq_e;

  typedef struct packed {
    seq_e              seq;
    logic [CND_W-1:0]  cnd;
    logic [CTL_W-1:0]  ctl;
    logic [LD_W-1:0]   ld;
    logic [OE_W-1:0]   oe;
    logic [ADDR_W-1:0] br;
  } uword_t;
endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output uword_t            word
);
  always_comb begin
    word = '0;
    case (addr)
      5'd0:  word = '{SEQ_INC, 2'd0, 4'b0001, 3'd1, 4'd1,  5'd0};
      5'd1:  word = '{SEQ_MAP, 2'd0, 4'b0010, 3'd0, 4'd0,  5'd0};
      5'd2:  word = '{SEQ_JMP, 2'd0, 4'b0000, 3'd0, 4'd0,  5'd0};
      5'd3:  word = '{SEQ_INC, 2'd0, 4'b0100, 3'd2, 4'd2,  5'd0};
      5'd4:  word = '{SEQ_JMP, 2'd0, 4'b0000, 3'd0, 4'd3,  5'd0};
      5'd5:  word = '{SEQ_CND, 2'd0, 4'b0000, 3'd0, 4'd0,  5'd7};
      5'd6:  word = '{SEQ_JMP, 2'd0, 4'b0000, 3'd3, 4'd0,  5'd0};
      5'd7:  word = '{SEQ_JMP, 2'd0, 4'b1000, 3'd4, 4'd5,  5'd0};
      5'd8:  word = '{SEQ_CND, 2'd1, 4'b0000, 3'd0, 4'd0,  5'd10};
      5'd9:  word = '{SEQ_JMP, 2'd0, 4'b0000, 3'd0, 4'd6,  5'd0};
      5'd10: word = '{SEQ_JMP, 2'd0, 4'b0000, 3'd7, 4'd15, 5'd0};
      5'd11: word = '{SEQ_CND, 2'd2, 4'b0000, 3'd0, 4'd0,  5'd13};
      5'd12: word = '{SEQ_JMP, 2'd0, 4'b0011, 3'd0, 4'd9,  5'd0};
      5'd13: word = '{SEQ_JMP, 2'd0, 4'b0000, 3'd5, 4'd0,  5'd0};
      5'd14: word = '{SEQ_CND, 2'd3, 4'b0000, 3'd0, 4'd0,  5'd16};
      5'd15: word = '{SEQ_JMP, 2'd0, 4'b0000, 3'd0, 4'd12, 5'd0};
      5'd16: word = '{SEQ_JMP, 2'd0, 4'b0000, 3'd0, 4'd13, 5'd0};
      5'd17: word = '{SEQ_INC, 2'd0, 4'b0101, 3'd1, 4'd4,  5'd0};
      5'd18: word = '{SEQ_INC, 2'd0, 4'b1010, 3'd6, 4'd7,  5'd0};
      5'd19: word = '{SEQ_INC, 2'd0, 4'b1111, 3'd2, 4'd8,  5'd0};
      5'd20: word = '{SEQ_JMP, 2'd0, 4'b0000, 3'd0, 4'd10, 5'd0};
      5'd21: word = '{SEQ_JMP, 2'd0, 4'b0000, 3'd0, 4'd11, 5'd31};
      5'd31: word = '{SEQ_INC, 2'd0, 4'b0110, 3'd6, 4'd14, 5'd0};
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
(
  input  logic [ADDR_W-1:0] upc,
  input  uword_t            cw,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [NFLAG-1:0]  flags,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] inc_addr;
  logic [ADDR_W-1:0] map_addr;
  logic              cond_hit;

  assign inc_addr = upc + ADDR_W'(1);
  assign cond_hit = flags[cw.cnd];

  // opcode to routine start address
  always_comb begin
    map_addr = ADDR_W'(2);
    case (opcode)
      4'd0: map_addr = ADDR_W'(2);
      4'd1: map_addr = ADDR_W'(3);
      4'd2: map_addr = ADDR_W'(5);
      4'd3: map_addr = ADDR_W'(8);
      4'd4: map_addr = ADDR_W'(11);
      4'd5: map_addr = ADDR_W'(14);
      4'd6: map_addr = ADDR_W'(17);
      4'd7: map_addr = ADDR_W'(21);
      default: map_addr = ADDR_W'(2);
    endcase
  end

  always_comb begin
    case (cw.seq)
      SEQ_INC: nxt = inc_addr;
      SEQ_JMP: nxt = cw.br;
      SEQ_CND: nxt = cond_hit ? cw.br : inc_addr;
      default: nxt = map_addr;
    endcase
  end
endmodule

// File: rtl/useq_field_dec.sv
module useq_field_dec #(
  parameter int CODE_W = 3,
  localparam int NOUT  = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [NOUT-1:0]   stb
);
  // code 0 is reserved: it raises no strobe
  assign stb[0] = 1'b0;
  for (genvar k = 1; k < NOUT; k++) begin : g_out
    assign stb[k] = (code == CODE_W'(k));
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OPC_W-1:0]    opcode_i,
  input  logic [NFLAG-1:0]    flags_i,
  output logic [ADDR_W-1:0]   upc_o,
  output logic                adv_o,
  output logic [CTL_W-1:0]    ctl_o,
  output logic [NLD-1:0]      ld_stb_o,
  output logic [NOE-1:0]      oe_stb_o
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] upc_q, upc_d, nxt_addr;
  uword_t            cw_q, cw_d, rom_word;
  logic              ph_q, ph_d;
  logic              cw_en, upc_en;

  useq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  useq_store u_store (.addr(upc_q), .word(rom_word));

  useq_next_addr u_nxt (
    .upc(upc_q), .cw(cw_q), .opcode(opcode_i), .flags(flags_i), .nxt(nxt_addr)
  );

  // phase 0 enables the control word load, phase 1 the counter advance
  assign cw_en  = ~ph_q;
  assign upc_en =  ph_q;

  always_comb begin
    ph_d  = ~ph_q;
    cw_d  = cw_en  ? rom_word : cw_q;
    upc_d = upc_en ? nxt_addr : upc_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ph_q  <= 1'b0;
      cw_q  <= '0;
      upc_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cw_q  <= cw_d;
      upc_q <= upc_d;
    end
  end

  useq_field_dec #(.CODE_W(LD_W)) u_ld_dec (.code(cw_q.ld), .stb(ld_stb_o));
  useq_field_dec #(.CODE_W(OE_W)) u_oe_dec (.code(cw_q.oe), .stb(oe_stb_o));

  assign upc_o = upc_q;
  assign adv_o = ph_q;
  assign ctl_o = cw_q.ctl;

  // R2
  phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (adv_o != $past(adv_o)));
  // R2
  upc_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !adv_o |=> $stable(upc_o));
  // R2
  cw_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    adv_o |=> ($stable(ctl_o) && $stable(ld_stb_o) && $stable(oe_stb_o)));
  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (adv_o && cw_q.seq == SEQ_INC) |=> (upc_o == $past(upc_o) + ADDR_W'(1)));
  // R4
  jmp_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (adv_o && cw_q.seq == SEQ_JMP) |=> (upc_o == $past(cw_q.br)));
  // R7
  ld_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(ld_stb_o) && !ld_stb_o[0]);
  // R8
  oe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(oe_stb_o) && !oe_stb_o[0]);
endmodule

// File: tb/tb_useq_sequencer.sv
module tb_useq_sequencer;
  import useq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  opcode_i, flags_i;
  logic [4:0]  upc_o;
  logic        adv_o;
  logic [3:0]  ctl_o;
  logic [7:0]  ld_stb_o;
  logic [15:0] oe_stb_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  useq_sequencer dut (.*);

  // bench model state
  typedef struct { int seq, cnd, ctl, ld, oe, br; } tw_t;
  int m_s1 = 0, m_s2 = 0, m_upc = 0, m_ph = 0;
  tw_t m_cw = '{0,0,0,0,0,0};
  string m_tag = "R1";

  function automatic tw_t tw(int s, int c, int t, int l, int o, int b);
    tw_t w; w.seq = s; w.cnd = c; w.ctl = t; w.ld = l; w.oe = o; w.br = b;
    return w;
  endfunction

  function automatic tw_t tb_rom(int a);
    case (a)
      0:  return tw(0,0,1,1,1,0);
      1:  return tw(3,0,2,0,0,0);
      2:  return tw(1,0,0,0,0,0);
      3:  return tw(0,0,4,2,2,0);
      4:  return tw(1,0,0,0,3,0);
      5:  return tw(2,0,0,0,0,7);
      6:  return tw(1,0,0,3,0,0);
      7:  return tw(1,0,8,4,5,0);
      8:  return tw(2,1,0,0,0,10);
      9:  return tw(1,0,0,0,6,0);
      10: return tw(1,0,0,7,15,0);
      11: return tw(2,2,0,0,0,13);
      12: return tw(1,0,3,0,9,0);
      13: return tw(1,0,0,5,0,0);
      14: return tw(2,3,0,0,0,16);
      15: return tw(1,0,0,0,12,0);
      16: return tw(1,0,0,0,13,0);
      17: return tw(0,0,5,1,4,0);
      18: return tw(0,0,10,6,7,0);
      19: return tw(0,0,15,2,8,0);
      20: return tw(1,0,0,0,10,0);
      21: return tw(1,0,0,0,11,31);
      31: return tw(0,0,6,6,14,0);
      default: return tw(0,0,0,0,0,0);
    endcase
  endfunction

  function automatic int start_of(int op);
    int tbl [8] = '{2, 3, 5, 8, 11, 14, 17, 21};
    return (op < 8) ? tbl[op] : 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_upc = 0; m_ph = 0; m_cw = tw(0,0,0,0,0,0); m_tag = "R1";
    end else if (m_s2 == 0) begin
      m_s2 = m_s1; m_s1 = 1; m_tag = "R1";
    end else if (m_ph == 0) begin
      m_cw = tb_rom(m_upc); m_ph = 1;
    end else begin
      case (m_cw.seq)
        0: begin m_tag = (m_upc == 31) ? "R10" : "R3"; m_upc = (m_upc + 1) % 32; end
        1: begin m_tag = "R4"; m_upc = m_cw.br; end
        2: begin m_tag = "R5"; m_upc = flags_i[m_cw.cnd] ? m_cw.br : (m_upc + 1) % 32; end
        default: begin m_tag = "R6"; m_upc = start_of(opcode_i); end
      endcase
      m_ph = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int e_ld, e_oe;
    e_ld = (m_cw.ld == 0) ? 0 : (1 << m_cw.ld);
    e_oe = (m_cw.oe == 0) ? 0 : (1 << m_cw.oe);
    chk(int'(upc_o) == m_upc, m_tag, "upc (R11 inputs)", upc_o, m_upc);
    chk(int'(adv_o) == m_ph, (m_tag == "R1") ? "R1" : "R2", "adv", adv_o, m_ph);
    chk(int'(ctl_o) == m_cw.ctl, (m_tag == "R1") ? "R1" : "R9", "ctl", ctl_o, m_cw.ctl);
    chk(int'(ld_stb_o) == e_ld, (m_tag == "R1") ? "R1" : "R7", "ld_stb", ld_stb_o, e_ld);
    chk(int'(oe_stb_o) == e_oe, (m_tag == "R1") ? "R1" : "R8", "oe_stb", oe_stb_o, e_oe);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_0c41));
    rst_n = 1'b0; opcode_i = '0; flags_i = '0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); check_all(); end
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      check_all();
      if (cyc == 3000 || cyc == 3001 || cyc == 3002) rst_n = 1'b0;
      else rst_n = 1'b1;
      opcode_i = 4'($urandom);
      if (cyc < 600)       flags_i = 4'hF;     // every conditional taken (R5)
      else if (cyc < 1200) flags_i = 4'h0;     // every conditional not taken (R5)
      else                 flags_i = 4'($urandom);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule